// File: doc/BRIEF.md
# Endpoint Transmit-Ready Interrupt Controller

This block sits between a local microcontroller and the transmit side of a USB device with three endpoints that can send to the host using bulk or interrupt transfers. It keeps one packet-ready flag and one interrupt status bit for each endpoint, and it drives one active-low interrupt pin. Firmware loads a packet into the endpoint FIFO, then writes 1 to that endpoint's ready bit to arm it. The block later clears the ready bit when the FIFO can take a new packet. Clearing the ready bit is the ready event, and the block raises the endpoint's status bit at that event if the endpoint's interrupt enable is set.

Each endpoint runs its own four-state machine:

| State | Meaning | Ready bit |
|---|---|---|
| `S_FIRST` | First packet since reset or reconfiguration | 0 |
| `S_LOAD` | Firmware may fill the FIFO | 0 |
| `S_ARMED` | A packet is queued and waits for the host's ACK | 1 |
| `S_DRAIN` | The ACK has arrived and the block waits for FIFO space | 1 |

The transitions are:

- `first_go`: `S_FIRST` to `S_LOAD` on FIFO space. This is the ready event.
- `first_arm`: `S_FIRST` to `S_ARMED` on a firmware arm.
- `load_arm`: `S_LOAD` to `S_ARMED` on a firmware arm.
- `ack_go`: `S_ARMED` to `S_LOAD` on an ACK with FIFO space in the same cycle. This is a ready event.
- `ack_wait`: `S_ARMED` to `S_DRAIN` on an ACK without FIFO space.
- `drain_go`: `S_DRAIN` to `S_LOAD` on FIFO space. This is a ready event.
- `reconfig`: any state to `S_FIRST` when the endpoint is not configured for transmit.

The first packet therefore depends only on FIFO space. Every later packet also needs the host's ACK. A NAK or a timeout is simply the absence of an ACK, so it leaves the endpoint armed.

The register images keep fixed bit positions:

- Interrupt enable and status: bit 1 for EP1, bit 2 for EP2, bit 7 for EP3.
- Packet-ready: bits 5, 6 and 7 for EP1, EP2 and EP3.

EP1 and EP2 take a direction bit, where 1 selects transmit. EP3 can only transmit and ignores its direction bit. The arm input carries the bits firmware writes to the packet-ready register, and only the bits that are 1 have an effect. The packet's length plays no part, so a short packet is armed exactly like a full one.

Top module: `txrdy_irq_ctrl`

## Requirements
- R1: After reset every ready bit and status bit is 0 and `irq_n_o` is 1.
- R2: For the first packet after reset, FIFO space on a transmit-configured endpoint is enough for the ready event. One cycle later the endpoint's status bit is 1 if it was enabled, and its ready bit stays 0. No ACK is needed.
- R3: A 1 written to an endpoint's ready bit (bit 5, 6 or 7) while that bit is clear has three effects. The ready bit reads 1 on the next cycle. The status bit reads 0 on the next cycle. `irq_n_o` releases in the cycle of the write, unless another endpoint still holds it.
- R4: Once armed, an endpoint ignores FIFO space until a host ACK arrives. The ready bit stays 1 and no status is raised. After the ACK, the next cycle with FIFO space clears the ready bit and raises status if enabled.
- R5: Status is set only if the enable bit (bit 1, 2 or 7) is 1 in the cycle of the ready event. Setting the enable bit later sets nothing.
- R6: EP1 and EP2 with direction 0 never raise status or set ready. Dropping the direction bit returns the endpoint to the first-packet state, with ready and status cleared. EP3 ignores its direction bit.
- R7: `irq_n_o` is low exactly when some endpoint has both its status bit and its enable bit set. Clearing the enable bit releases the pin but leaves the status bit set.
- R8: Bits of the three registers that belong to no endpoint always read 0, and writes to them have no effect.
- R9: A write of 1 to a ready bit that is already set changes nothing.
- R10: An ACK together with FIFO space in the same cycle clears the ready bit on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| int_en_i | input | 8 | Interrupt enable image (bits 1, 2, 7) |
| cfg_dir_i | input | 3 | Per-endpoint direction, 1 = transmit (EP3 ignored) |
| rdy_wr_i | input | 8 | One-cycle firmware write of 1s to the ready register (bits 5, 6, 7) |
| fifo_space_i | input | 3 | Endpoint FIFO can accept a new packet |
| host_ack_i | input | 3 | One-cycle host ACK for the packet just sent |
| rdy_o | output | 8 | Packet-ready image (bits 5, 6, 7) |
| stat_o | output | 8 | Interrupt status image (bits 1, 2, 7) |
| irq_n_o | output | 1 | Active-low interrupt pin |

## Verification
The hardest situation to reach is the difference between a first packet and a later one. The first ready event needs no ACK. After an arm, FIFO space alone must have no effect for as long as the ACK is missing. The bench reaches this by arming an endpoint and then holding FIFO space for several cycles with no ACK. It then sends a lone ACK, then FIFO space on its own, then an ACK and FIFO space together. Each of these runs for every combination of endpoint, enable and direction. For EP1 and EP2 the bench also drops the direction bit and restores it, then checks that FIFO space alone raises status again.

// File: rtl/txrdy_pkg.sv
package txrdy_pkg;

    localparam int NUM_EP = 3;
    localparam int REG_W  = 8;

    typedef enum logic [1:0] {
        S_FIRST = 2'd0,
        S_LOAD  = 2'd1,
        S_ARMED = 2'd2,
        S_DRAIN = 2'd3
    } ep_state_e;

    // bit position of an endpoint in the enable and status images
    function automatic int en_pos(input int ep);
        return (ep == 0) ? 1 : (ep == 1) ? 2 : 7;
    endfunction

    // bit position of an endpoint in the packet-ready image
    function automatic int rdy_pos(input int ep);
        return 5 + ep;
    endfunction

endpackage

// File: rtl/txrdy_ep_fsm.sv
module txrdy_ep_fsm
    import txrdy_pkg::*;
#(
    parameter bit TX_ONLY = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_dir,
    input  logic int_en,
    input  logic fw_arm,
    input  logic fifo_space,
    input  logic host_ack,
    output logic pkt_rdy,
    output logic stat,
    output logic arm_take
);

    ep_state_e state, nxt;
    logic      tx_ok;
    logic      raise;

    generate
        if (TX_ONLY) begin : g_tx_only
            logic unused_dir;
            assign unused_dir = cfg_dir;
            assign tx_ok      = 1'b1;
        end else begin : g_dir
            assign tx_ok = cfg_dir;
        end
    endgenerate

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_FIRST;
        else        state <= nxt;
    end

    // next state and event decode
    always_comb begin
        nxt      = state;
        raise    = 1'b0;
        arm_take = 1'b0;
        if (!tx_ok) begin
            nxt = S_FIRST;                        // reconfig
        end else begin
            unique case (state)
                S_FIRST: begin
                    if (fw_arm) begin             // first_arm
                        nxt      = S_ARMED;
                        arm_take = 1'b1;
                    end else if (fifo_space) begin // first_go
                        nxt   = S_LOAD;
                        raise = 1'b1;
                    end
                end
                S_LOAD: begin
                    if (fw_arm) begin             // load_arm
                        nxt      = S_ARMED;
                        arm_take = 1'b1;
                    end
                end
                S_ARMED: begin
                    if (host_ack) begin
                        if (fifo_space) begin     // ack_go
                            nxt   = S_LOAD;
                            raise = 1'b1;
                        end else begin            // ack_wait
                            nxt = S_DRAIN;
                        end
                    end
                end
                S_DRAIN: begin
                    if (fifo_space) begin         // drain_go
                        nxt   = S_LOAD;
                        raise = 1'b1;
                    end
                end
                default: nxt = S_FIRST;
            endcase
        end
    end

    // status bit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               stat <= 1'b0;
        else if (raise && int_en) stat <= 1'b1;
        else if (arm_take || !tx_ok) stat <= 1'b0;
    end

    // outputs
    always_comb begin
        pkt_rdy = (state == S_ARMED) || (state == S_DRAIN);
    end

    p_hold_without_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ARMED && !host_ack && tx_ok) |=> (pkt_rdy && !stat));

    p_status_needs_enable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat) |-> $past(int_en));

    p_status_on_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat) |-> (state == S_LOAD && !pkt_rdy));

    p_dir_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_ok |=> (!pkt_rdy && !stat));

    p_arm_sets_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
        arm_take |=> (pkt_rdy && !stat));

endmodule

// File: rtl/txrdy_irq_merge.sv
module txrdy_irq_merge #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] stat,
    input  logic [N-1:0] en,
    input  logic [N-1:0] arm_take,
    output logic         irq_n
);

    logic [N-1:0] live;

    always_comb begin
        live  = stat & en & ~arm_take;
        irq_n = ~|live;
    end

    p_pin_needs_status_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> (|stat));

endmodule

// File: rtl/txrdy_irq_ctrl.sv
module txrdy_irq_ctrl
    import txrdy_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] int_en_i,
    input  logic [NUM_EP-1:0] cfg_dir_i,
    input  logic [REG_W-1:0] rdy_wr_i,
    input  logic [NUM_EP-1:0] fifo_space_i,
    input  logic [NUM_EP-1:0] host_ack_i,
    output logic [REG_W-1:0] rdy_o,
    output logic [REG_W-1:0] stat_o,
    output logic             irq_n_o
);

    logic [NUM_EP-1:0] en_v, arm_v, rdy_v, stat_v, take_v;
    logic [REG_W-1:0]  en_mask, rdy_mask;
    logic              unused_bits;

    always_comb begin
        en_mask  = '0;
        rdy_mask = '0;
        for (int i = 0; i < NUM_EP; i++) begin
            en_v[i]            = int_en_i[en_pos(i)];
            arm_v[i]           = rdy_wr_i[rdy_pos(i)];
            en_mask[en_pos(i)]   = 1'b1;
            rdy_mask[rdy_pos(i)] = 1'b1;
        end
    end

    assign unused_bits = ^{int_en_i & ~en_mask, rdy_wr_i & ~rdy_mask};

    generate
        for (genvar g = 0; g < NUM_EP; g++) begin : g_ep
            txrdy_ep_fsm #(.TX_ONLY(g == NUM_EP - 1)) u_ep (
                .clk        (clk),
                .rst_n      (rst_n),
                .cfg_dir    (cfg_dir_i[g]),
                .int_en     (en_v[g]),
                .fw_arm     (arm_v[g]),
                .fifo_space (fifo_space_i[g]),
                .host_ack   (host_ack_i[g]),
                .pkt_rdy    (rdy_v[g]),
                .stat       (stat_v[g]),
                .arm_take   (take_v[g])
            );
        end
    endgenerate

    always_comb begin
        rdy_o  = '0;
        stat_o = '0;
        for (int i = 0; i < NUM_EP; i++) begin
            rdy_o[rdy_pos(i)] = rdy_v[i];
            stat_o[en_pos(i)] = stat_v[i];
        end
    end

    txrdy_irq_merge #(.N(NUM_EP)) u_merge (
        .clk      (clk),
        .rst_n    (rst_n),
        .stat     (stat_v),
        .en       (en_v),
        .arm_take (take_v),
        .irq_n    (irq_n_o)
    );

    p_spare_bits_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((rdy_o & ~rdy_mask) == '0) && ((stat_o & ~en_mask) == '0));

endmodule

// File: tb/txrdy_irq_ctrl_test.sv
module txrdy_irq_ctrl_test;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] int_en_i = '0;
    logic [2:0] cfg_dir_i = '0;
    logic [7:0] rdy_wr_i = '0;
    logic [2:0] fifo_space_i = '0;
    logic [2:0] host_ack_i = '0;
    logic [7:0] rdy_o, stat_o;
    logic       irq_n_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    txrdy_irq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .int_en_i(int_en_i), .cfg_dir_i(cfg_dir_i),
        .rdy_wr_i(rdy_wr_i), .fifo_space_i(fifo_space_i), .host_ack_i(host_ack_i),
        .rdy_o(rdy_o), .stat_o(stat_o), .irq_n_o(irq_n_o)
    );

    function automatic int enp(input int ep);
        return (ep == 0) ? 1 : (ep == 1) ? 2 : 7;
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        int_en_i = '0; cfg_dir_i = '0; rdy_wr_i = '0;
        fifo_space_i = '0; host_ack_i = '0;
        tick(); tick();
        rst_n = 1'b1;
        tick();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();
        chk("R1 ready", rdy_o, 8'h00);
        chk("R1 status", stat_o, 8'h00);
        chk("R1 pin", {7'd0, irq_n_o}, 8'h01);

        for (int ep = 0; ep < 3; ep++) begin
            for (int en = 0; en < 2; en++) begin
                for (int dir = 0; dir < 2; dir++) begin
                    logic       txok;
                    logic [7:0] ebit, rbit, sexp;
                    txok = (dir == 1) || (ep == 2);
                    ebit = 8'h01 << enp(ep);
                    rbit = 8'h01 << (5 + ep);
                    sexp = (en == 1 && txok) ? ebit : 8'h00;
                    do_reset();
                    // spare bits written as 1 to check R8
                    int_en_i  = (en == 1) ? (ebit | 8'h79) : 8'h79;
                    cfg_dir_i = dir[0] ? (3'b001 << ep) : 3'b000;
                    tick();
                    fifo_space_i[ep] = 1'b1;
                    tick();
                    fifo_space_i = '0;
                    chk("R2 R5 R6 first status", stat_o, sexp);
                    chk("R2 first ready", rdy_o, 8'h00);
                    chk("R7 pin", {7'd0, irq_n_o}, {7'd0, ~(en == 1 && txok)});
                    if (!txok) begin
                        rdy_wr_i = rbit;
                        tick();
                        rdy_wr_i = '0;
                        chk("R6 arm blocked", rdy_o, 8'h00);
                        continue;
                    end
                    if (en == 0) begin
                        int_en_i = ebit;
                        #1;
                        chk("R5 late enable status", stat_o, 8'h00);
                        chk("R5 late enable pin", {7'd0, irq_n_o}, 8'h01);
                        int_en_i = 8'h79;
                    end else begin
                        int_en_i = 8'h00;
                        #1;
                        chk("R7 disable pin", {7'd0, irq_n_o}, 8'h01);
                        chk("R7 status kept", stat_o, ebit);
                        int_en_i = ebit | 8'h79;
                        #1;
                        chk("R7 re-enable pin", {7'd0, irq_n_o}, 8'h00);
                    end
                    rdy_wr_i = rbit | 8'h1F;
                    #1;
                    chk("R3 same-cycle pin", {7'd0, irq_n_o}, 8'h01);
                    tick();
                    rdy_wr_i = '0;
                    chk("R3 R8 ready", rdy_o, rbit);
                    chk("R3 status", stat_o, 8'h00);
                    rdy_wr_i = rbit;
                    tick();
                    rdy_wr_i = '0;
                    chk("R9 rearm ready", rdy_o, rbit);
                    chk("R9 rearm status", stat_o, 8'h00);
                    fifo_space_i[ep] = 1'b1;
                    tick(); tick(); tick();
                    fifo_space_i = '0;
                    chk("R4 no ack ready", rdy_o, rbit);
                    chk("R4 no ack status", stat_o, 8'h00);
                    chk("R4 no ack pin", {7'd0, irq_n_o}, 8'h01);
                    host_ack_i[ep] = 1'b1;
                    tick();
                    host_ack_i = '0;
                    chk("R4 ack waits space", rdy_o, rbit);
                    tick();
                    chk("R4 still waiting", rdy_o, rbit);
                    fifo_space_i[ep] = 1'b1;
                    tick();
                    fifo_space_i = '0;
                    chk("R4 ready cleared", rdy_o, 8'h00);
                    chk("R4 status", stat_o, sexp);
                    rdy_wr_i = rbit;
                    tick();
                    rdy_wr_i = '0;
                    host_ack_i[ep] = 1'b1;
                    fifo_space_i[ep] = 1'b1;
                    tick();
                    host_ack_i = '0;
                    fifo_space_i = '0;
                    chk("R10 ready", rdy_o, 8'h00);
                    chk("R10 status", stat_o, sexp);
                    if (ep < 2) begin
                        rdy_wr_i = rbit;
                        tick();
                        rdy_wr_i = '0;
                        cfg_dir_i = '0;
                        tick();
                        chk("R6 reconfig ready", rdy_o, 8'h00);
                        chk("R6 reconfig status", stat_o, 8'h00);
                        cfg_dir_i = 3'b001 << ep;
                        fifo_space_i[ep] = 1'b1;
                        tick();
                        fifo_space_i = '0;
                        chk("R6 first again", stat_o, sexp);
                    end
                end
            end
        end

        // shared pin across endpoints
        do_reset();
        int_en_i = 8'h86;
        cfg_dir_i = 3'b011;
        fifo_space_i = 3'b111;
        tick();
        fifo_space_i = '0;
        chk("R7 all status", stat_o, 8'h86);
        rdy_wr_i = 8'h20;
        #1;
        chk("R7 pin held by others", {7'd0, irq_n_o}, 8'h00);
        tick();
        rdy_wr_i = 8'hC0;
        #1;
        chk("R3 R7 pin released", {7'd0, irq_n_o}, 8'h01);
        tick();
        rdy_wr_i = '0;
        chk("R3 all armed", rdy_o, 8'hE0);
        chk("R3 all status clear", stat_o, 8'h00);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule